// File: doc/BRIEF.md
# RTC interrupt flag register

This block is the interrupt status register of a real-time clock. It watches three event sources. The first is a periodic tick, taken from one tap of a free-running divider. The second is a single-cycle pulse that signals an alarm match. The third is a single-cycle pulse that marks the end of a time update. Each event sets its own sticky flag.

Each flag is ANDed with its own enable bit, and the three results are ORed into a summary request bit. A registered, active-low interrupt pin follows that request bit. The host reads one status byte by pulsing a read strobe. The byte shows the flags as they stood before the read, and the read then clears every flag. The reset input clears the flags as well.

The enable bits and the 4-bit rate code arrive as plain inputs from a control register elsewhere. The alarm comparator and the time counters also sit outside this block.

Top module: `rtc_irq_status`

## Requirements
- R1: `rd_data` carries the status byte. Bit 7 is the summary request bit, bit 6 is the periodic flag, bit 5 is the alarm flag and bit 4 is the update flag. Bits 3 to 0 always read 0.
- R2: A nonzero `rate_sel` value k (1 to 15) sets the periodic flag once every 2^k clock cycles, whatever the value of `per_en`.
- R3: A `rate_sel` value of 0 never sets the periodic flag.
- R4: A one-cycle pulse on `alarm_hit` sets the alarm flag, and a one-cycle pulse on `upd_done` sets the update flag. Both flags set whatever their enables are.
- R5: A set flag stays set across any number of cycles until a status read or a reset.
- R6: In a cycle with `rd_stb` high, `rd_data` shows the flags as they were before the read. All flags are 0 from the following clock edge.
- R7: An event in the same cycle as a status read is not lost. Its flag is set after that read, and the next read reports it.
- R8: The summary bit is (periodic flag AND `per_en`) OR (alarm flag AND `alm_en`) OR (update flag AND `upd_en`). It follows a change of an enable within the same cycle.
- R9: `irq_n` is low one clock after the summary bit becomes 1. It returns high one clock after the summary bit returns to 0.
- R10: While `rst` is high, every flag and the summary bit read 0 and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high, clears all flags |
| rd_stb | input | 1 | Status read strobe, one cycle per read |
| rate_sel | input | RATE_W (4) | Periodic rate code; 0 turns the periodic tap off |
| per_en | input | 1 | Periodic interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| upd_en | input | 1 | Update-done interrupt enable |
| alarm_hit | input | 1 | Alarm match pulse |
| upd_done | input | 1 | Update-cycle complete pulse |
| rd_data | output | 8 | Status byte |
| irq_n | output | 1 | Interrupt request pin, active low |

## Verification
The assertions assume that `alarm_hit` and `upd_done` are already synchronous to `clk`. They also assume that a pulse on either of them lasts one cycle, and that `rate_sel` changes only while the periodic flag is not being timed.

The stimulus drives every input just after a rising edge and raises each event for exactly one cycle. It changes `rate_sel` only between measurements, and it clears any periodic flag left over from a previous rate before it starts timing the new one.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } rtc_flags_t;

    typedef struct packed {
        logic pie;
        logic aie;
        logic uie;
    } rtc_enables_t;

    localparam int STATUS_W = 8;

    function automatic logic [STATUS_W-1:0] pack_status(logic irqf, rtc_flags_t f);
        return {irqf, f.pf, f.af, f.uf, 4'b0000};
    endfunction

endpackage

// File: rtl/rtc_irq_divider.sv
module rtc_irq_divider #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              tap_evt
);
    localparam int NUM_CODES = 1 << RATE_W;
    localparam int DIV_W     = NUM_CODES - 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [NUM_CODES-1:0] tap_hit;

    // Code k fires when the low k counter bits equal 2^(k-1),
    // which is the rising edge of counter bit k-1.
    assign tap_hit[0] = 1'b0;
    generate
        for (genvar k = 1; k < NUM_CODES; k++) begin : g_tap
            if (k == 1) begin : g_first
                assign tap_hit[k] = s_q.cnt[0];
            end else begin : g_upper
                assign tap_hit[k] = s_q.cnt[k-1] & ~(|s_q.cnt[k-2:0]);
            end
        end
    endgenerate

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + {{(DIV_W-1){1'b0}}, 1'b1};
        tap_evt = tap_hit[rate_sel];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R3: the off code never produces a tick
    a_r3_off_code_silent: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == '0) |-> !tap_evt);

    // R2: with the rate held, ticks never fall in two cycles in a row
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tap_evt |=> (!$stable(rate_sel) || !tap_evt));

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  rtc_enables_t en,
    input  logic         per_evt,
    input  logic         alarm_evt,
    input  logic         upd_evt,
    input  logic         rd_clr,
    output rtc_flags_t   flags,
    output logic         irqf,
    output logic         irq_n
);
    typedef struct packed {
        rtc_flags_t flg;
        logic       irq_n;
    } fl_state_t;

    localparam fl_state_t RESET_S = '{flg: '0, irq_n: 1'b1};

    fl_state_t s_d, s_q;

    always_comb begin
        irqf = (s_q.flg.pf & en.pie) | (s_q.flg.af & en.aie) | (s_q.flg.uf & en.uie);
        s_d  = s_q;
        if (rd_clr) begin
            s_d.flg = '0;
        end
        // Events are merged after the clear so a coincident one survives.
        s_d.flg.pf = s_d.flg.pf | per_evt;
        s_d.flg.af = s_d.flg.af | alarm_evt;
        s_d.flg.uf = s_d.flg.uf | upd_evt;
        s_d.irq_n  = ~irqf;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) s_q <= RESET_S;
        else     s_q <= s_d;
    end

    assign flags = s_q.flg;
    assign irq_n = s_q.irq_n;

    a_r4_alarm_sets: assert property (@(posedge clk) disable iff (rst)
        alarm_evt |=> flags.af);

    a_r2_tick_sets_pf: assert property (@(posedge clk) disable iff (rst)
        per_evt |=> flags.pf);

    a_r5_uf_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags.uf && !rd_clr) |=> flags.uf);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !per_evt && !alarm_evt && !upd_evt) |=> (flags == '0));

    a_r9_pin_low: assert property (@(posedge clk) disable iff (rst)
        irqf |=> !irq_n);

    a_r9_pin_high: assert property (@(posedge clk) disable iff (rst)
        !irqf |=> irq_n);

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              per_en,
    input  logic              alm_en,
    input  logic              upd_en,
    input  logic              alarm_hit,
    input  logic              upd_done,
    output logic [7:0]        rd_data,
    output logic              irq_n
);
    import rtc_irq_pkg::*;

    logic         tap_evt;
    rtc_flags_t   flags;
    rtc_enables_t en;
    logic         irqf;

    assign en = '{pie: per_en, aie: alm_en, uie: upd_en};

    rtc_irq_divider #(.RATE_W(RATE_W)) div_i (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .tap_evt  (tap_evt)
    );

    rtc_irq_flags flags_i (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .per_evt   (tap_evt),
        .alarm_evt (alarm_hit),
        .upd_evt   (upd_done),
        .rd_clr    (rd_stb),
        .flags     (flags),
        .irqf      (irqf),
        .irq_n     (irq_n)
    );

    assign rd_data = pack_status(irqf, flags);

    // R8: with no flag set the request bit stays clear
    a_r8_no_flag_no_req: assert property (@(posedge clk) disable iff (rst)
        (rd_data[6:4] == 3'b000) |-> !rd_data[7]);

endmodule

// File: tb/rtc_irq_status_tb_top.sv
module rtc_irq_status_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_stb = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       per_en = 1'b0, alm_en = 1'b0, upd_en = 1'b0;
    logic       alarm_hit = 1'b0, upd_done = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    typedef struct {
        logic [7:0] data;
        logic [7:0] mask;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    rtc_irq_status #(.RATE_W(4)) dut_i (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .rate_sel(rate_sel),
        .per_en(per_en), .alm_en(alm_en), .upd_en(upd_en),
        .alarm_hit(alarm_hit), .upd_done(upd_done),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compares each status read against the queued expectation.
    always @(negedge clk) begin
        exp_t e;
        if (rd_stb && !rst) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R6", "read with no expectation", rd_data, 0);
            end else begin
                e = sb_q.pop_front();
                check((rd_data & e.mask) == (e.data & e.mask), e.tag, "status read",
                      rd_data & e.mask, e.data & e.mask);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic read_exp(logic [7:0] exp, string tag);
        sb_q.push_back('{exp, 8'hFF, tag});
        rd_stb = 1'b1;
        step(1);
        rd_stb = 1'b0;
    endtask

    task automatic read_any();
        sb_q.push_back('{8'h00, 8'h0F, "R1"});
        rd_stb = 1'b1;
        step(1);
        rd_stb = 1'b0;
    endtask

    task automatic pulse_alarm();
        alarm_hit = 1'b1;
        step(1);
        alarm_hit = 1'b0;
    endtask

    task automatic pulse_upd();
        upd_done = 1'b1;
        step(1);
        upd_done = 1'b0;
    endtask

    task automatic wait_fall(output int t);
        int guard = 0;
        while (irq_n === 1'b1 && guard < 5000) begin
            step(1);
            guard++;
        end
        check(guard < 5000, "R2", "periodic tick timeout", guard, 0);
        t = cyc;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int t1;
        int t2;
        step(3);
        // R10: reset state
        check(rd_data == 8'h00, "R10", "status in reset", rd_data, 0);
        check(irq_n == 1'b1, "R10", "pin in reset", irq_n, 1);
        rst = 1'b0;
        step(1);

        // R4 / R8: alarm flag sets with its enable off, pin stays high
        pulse_alarm();
        step(1);
        check(irq_n == 1'b1, "R8", "pin with alarm disabled", irq_n, 1);
        read_exp(8'h20, "R4");
        read_exp(8'h00, "R6");

        // R5: update flag held over idle cycles
        pulse_upd();
        step(5);
        read_exp(8'h10, "R5");

        // R9: pin timing around set and clear
        alm_en = 1'b1;
        pulse_alarm();
        check(irq_n == 1'b1, "R9", "pin on set edge", irq_n, 1);
        step(1);
        check(irq_n == 1'b0, "R9", "pin one cycle later", irq_n, 0);
        read_exp(8'hA0, "R9");
        check(rd_data == 8'h00, "R6", "status after read", rd_data, 0);
        check(irq_n == 1'b0, "R9", "pin on clearing edge", irq_n, 0);
        step(1);
        check(irq_n == 1'b1, "R9", "pin released", irq_n, 1);
        alm_en = 1'b0;

        // R8: enable gating is combinational
        pulse_upd();
        step(2);
        check(irq_n == 1'b1, "R8", "pin with update disabled", irq_n, 1);
        check(rd_data == 8'h10, "R8", "no request bit", rd_data, 8'h10);
        upd_en = 1'b1;
        #1;
        check(rd_data == 8'h90, "R8", "request after enable", rd_data, 8'h90);
        step(1);
        check(irq_n == 1'b0, "R8", "pin after enable", irq_n, 0);
        read_exp(8'h90, "R8");
        upd_en = 1'b0;
        step(2);

        // R7: event coinciding with a read
        pulse_upd();
        sb_q.push_back('{8'h10, 8'hFF, "R7"});
        rd_stb = 1'b1;
        alarm_hit = 1'b1;
        step(1);
        rd_stb = 1'b0;
        alarm_hit = 1'b0;
        read_exp(8'h20, "R7");

        // R10: reset mid-operation
        alm_en = 1'b1;
        pulse_alarm();
        pulse_upd();
        step(1);
        check(irq_n == 1'b0, "R10", "pin before reset", irq_n, 0);
        rst = 1'b1;
        #1;
        check(rd_data == 8'h00, "R10", "flags during reset", rd_data, 0);
        check(irq_n == 1'b1, "R10", "pin during reset", irq_n, 1);
        step(1);
        rst = 1'b0;
        step(1);
        check(rd_data == 8'h00, "R10", "flags after reset", rd_data, 0);
        alm_en = 1'b0;

        // R2: periodic flag sets with its enable off
        rate_sel = 4'd3;
        step(20);
        check(irq_n == 1'b1, "R2", "pin with periodic disabled", irq_n, 1);
        read_exp(8'h40, "R2");

        // R3: rate code 0 is silent
        rate_sel = 4'd0;
        step(2);
        read_any();
        step(300);
        read_exp(8'h00, "R3");

        // R2: period equals 2^k cycles
        per_en = 1'b1;
        foreach (sb_q[i]) begin end
        for (int k = 3; k <= 9; k += 3) begin
            rate_sel = 4'(k);
            step(2);
            read_any();
            step(1);
            wait_fall(t1);
            read_any();
            step(1);
            wait_fall(t2);
            check((t2 - t1) == (1 << k), "R2", "periodic interval", t2 - t1, 1 << k);
            read_any();
            step(1);
        end

        // R1: full status byte with all sources set
        rate_sel = 4'd3;
        alm_en = 1'b1;
        upd_en = 1'b1;
        read_any();
        pulse_alarm();
        pulse_upd();
        step(10);
        read_exp(8'hF0, "R1");
        rate_sel = 4'd0;
        step(2);

        check(sb_q.size() == 0, "R6", "pending expectations", sb_q.size(), 0);
        summary();
        $finish;
    end

endmodule